// File: doc/BRIEF.md
# Count-Based Thread Fetch Arbiter

This block decides, every cycle, which hardware thread of a simultaneous multithreading front end may fetch. It keeps three banks of per-thread saturating counters. The first bank counts instructions that each thread has in decode, rename and the issue queue. The second bank counts branches in those same stages. The third bank counts outstanding data-cache misses. Each counter is kept up to date by its own increment and decrement strobes, and every counter updates in every cycle, whatever the mode.

A 2-bit policy input chooses which bank drives priority. The grant goes to the fetch-eligible thread whose selected counter is the smallest. A fourth policy ignores the counters and simply rotates among the eligible threads. Equal counts are resolved by a rotating pointer, which moves to the thread after the last one granted. The grant is combinational from the current state and inputs. Counter and pointer updates take effect at the next rising clock edge.

Top module: `smt_fetch_arb`

## Requirements
- R1: After reset all counters are zero and the rotating pointer is at thread 0, so the first grant with every thread eligible goes to thread 0 (grant bit i means thread i).
- R2: The grant has at most one bit set, never names an ineligible thread, and is all zeros exactly when no thread is eligible.
- R3: With policy 0, the grant goes to the eligible thread with the smallest instruction counter (strobes ic_inc/ic_dec).
- R4: With policy 1, the grant goes to the eligible thread with the smallest branch counter (strobes br_inc/br_dec).
- R5: With policy 2, the grant goes to the eligible thread with the smallest miss counter (strobes ms_inc/ms_dec).
- R6: With policy 3, all counter values are ignored and the grant rotates among the eligible threads.
- R7: Among eligible threads that share the minimum value, the search starts at the pointer and goes upward with wraparound. After any nonzero grant, the pointer becomes the granted index plus one, modulo the thread count.
- R8: A counter at its maximum value (63 for 6 bits) stays there when it gets an increment without a decrement.
- R9: A counter at zero stays at zero when it gets a decrement without an increment.
- R10: An increment and a decrement on the same counter in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 instruction, 1 branch, 2 miss, 3 round-robin |
| elig | input | NT | Per-thread fetch-eligible flags |
| ic_inc | input | NT | Per-thread instruction counter increment |
| ic_dec | input | NT | Per-thread instruction counter decrement |
| br_inc | input | NT | Per-thread branch counter increment |
| br_dec | input | NT | Per-thread branch counter decrement |
| ms_inc | input | NT | Per-thread miss counter increment |
| ms_dec | input | NT | Per-thread miss counter decrement |
| grant | output | NT | One-hot fetch grant |

## Verification
The grant responds in the same cycle to changes in policy or eligibility. A strobe changes a counter, and the pointer moves, only at the next rising edge, so the strobe affects the grant one cycle after it is applied. The bench drives its inputs just after the falling edge and compares the grant a few nanoseconds later. It then updates its own model of the counters and pointer with those same inputs, which stand in for the rising edge that follows. Directed sequences bring counters to both saturation limits and hold increment and decrement together. Each sequence then shows the resulting state through which thread wins the grant.

// File: rtl/smt_fetch_arb.sv
module smt_fetch_arb #(
  parameter int NT = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [NT-1:0] elig,
  input  logic [NT-1:0] ic_inc,
  input  logic [NT-1:0] ic_dec,
  input  logic [NT-1:0] br_inc,
  input  logic [NT-1:0] br_dec,
  input  logic [NT-1:0] ms_inc,
  input  logic [NT-1:0] ms_dec,
  output logic [NT-1:0] grant
);
  localparam int NB = 3;
  localparam int PW = (NT > 1) ? $clog2(NT) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [NT-1:0] inc_v [NB];
  logic [NT-1:0] dec_v [NB];
  logic [CW-1:0] cnt [NB][NT];
  logic [CW-1:0] key [NT];
  logic [PW-1:0] ptr, gidx;
  logic          gany;

  assign inc_v[0] = ic_inc;
  assign inc_v[1] = br_inc;
  assign inc_v[2] = ms_inc;
  assign dec_v[0] = ic_dec;
  assign dec_v[1] = br_dec;
  assign dec_v[2] = ms_dec;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar t = 0; t < NT; t++) begin : g_thr
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          cnt[b][t] <= '0;
        else if (inc_v[b][t] && !dec_v[b][t] && cnt[b][t] != CMAX)
          cnt[b][t] <= cnt[b][t] + 1'b1;
        else if (dec_v[b][t] && !inc_v[b][t] && cnt[b][t] != '0)
          cnt[b][t] <= cnt[b][t] - 1'b1;

      // R8
      sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[b][t] == CMAX && inc_v[b][t] && !dec_v[b][t]) |=> cnt[b][t] == CMAX);
      // R9
      sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[b][t] == '0 && dec_v[b][t] && !inc_v[b][t]) |=> cnt[b][t] == '0);
      // R10
      inc_dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v[b][t] && dec_v[b][t]) |=> $stable(cnt[b][t]));
    end
  end

  always_comb
    for (int t = 0; t < NT; t++)
      case (mode)
        2'd0:    key[t] = cnt[0][t];
        2'd1:    key[t] = cnt[1][t];
        2'd2:    key[t] = cnt[2][t];
        default: key[t] = '0;
      endcase

  always_comb begin
    logic [CW-1:0] minv;
    minv = CMAX;
    for (int t = 0; t < NT; t++)
      if (elig[t] && key[t] < minv) minv = key[t];
    gany = 1'b0;
    gidx = '0;
    for (int i = 0; i < NT; i++) begin
      int j;
      j = (int'(ptr) + i) % NT;
      if (!gany && elig[j] && key[j] == minv) begin
        gany = 1'b1;
        gidx = PW'(j);
      end
    end
  end

  assign grant = gany ? (NT'(1) << gidx) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ptr <= '0;
    else if (gany)
      ptr <= PW'((int'(gidx) + 1) % NT);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R2
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~elig) == '0);
  // R2
  grant_live_chk: assert property (@(posedge clk) disable iff (!rst_n) (elig != '0) |-> (grant != '0));
  // R7
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ptr == PW'((int'($past(gidx)) + 1) % NT));
endmodule

// File: tb/smt_fetch_arb_tb.sv
`timescale 1ns/1ps
module smt_fetch_arb_tb_top;
  localparam int NT = 4;
  localparam int CMAX = 63;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [NT-1:0] elig = 0, ic_inc = 0, ic_dec = 0, br_inc = 0, br_dec = 0, ms_inc = 0, ms_dec = 0;
  logic [NT-1:0] grant;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_cnt [3][NT];
  int m_ptr;

  always #10 clk = ~clk;

  smt_fetch_arb #(.NT(NT), .CW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .elig(elig),
    .ic_inc(ic_inc), .ic_dec(ic_dec), .br_inc(br_inc), .br_dec(br_dec),
    .ms_inc(ms_inc), .ms_dec(ms_dec), .grant(grant));

  function automatic logic [NT-1:0] exp_grant();
    int best = 1000;
    int k;
    for (int t = 0; t < NT; t++) begin
      k = (mode == 3) ? 0 : m_cnt[mode][t];
      if (elig[t] && k < best) best = k;
    end
    for (int i = 0; i < NT; i++) begin
      int j = (m_ptr + i) % NT;
      k = (mode == 3) ? 0 : m_cnt[mode][j];
      if (elig[j] && k == best) return NT'(1) << j;
    end
    return '0;
  endfunction

  task automatic model_update(logic [NT-1:0] g);
    logic [NT-1:0] iv [3];
    logic [NT-1:0] dv [3];
    iv[0] = ic_inc; iv[1] = br_inc; iv[2] = ms_inc;
    dv[0] = ic_dec; dv[1] = br_dec; dv[2] = ms_dec;
    for (int b = 0; b < 3; b++)
      for (int t = 0; t < NT; t++)
        if (iv[b][t] && !dv[b][t] && m_cnt[b][t] < CMAX) m_cnt[b][t]++;
        else if (dv[b][t] && !iv[b][t] && m_cnt[b][t] > 0) m_cnt[b][t]--;
    for (int t = 0; t < NT; t++)
      if (g[t]) m_ptr = (t + 1) % NT;
  endtask

  task automatic cyc(input string tag, input bit chk);
    logic [NT-1:0] e;
    #2;
    e = exp_grant();
    if (chk) begin
      checks++;
      if (grant !== e) begin
        failures++;
        $display("FAIL %s: grant=%b expected=%b", tag, grant, e);
      end
    end
    model_update(e);
    @(negedge clk);
  endtask

  task automatic clr();
    ic_inc = 0; ic_dec = 0; br_inc = 0; br_dec = 0; ms_inc = 0; ms_dec = 0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    for (int b = 0; b < 3; b++) for (int t = 0; t < NT; t++) m_cnt[b][t] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state: all eligible, first grant thread 0
    mode = 0; elig = 4'b1111;
    cyc("R1", 1);
    mode = 3;
    cyc("R6", 1);
    cyc("R7", 1);
    cyc("R7", 1);
    // R2 nobody eligible
    elig = 0;
    cyc("R2", 1);

    // R8 saturation at top on thread 0 instruction counter
    mode = 0; elig = 4'b0011;
    ic_inc = 4'b0001;
    repeat (70) cyc("R3", 0);
    ic_inc = 4'b0010;
    repeat (63) cyc("R3", 0);
    ic_inc = 0; ic_dec = 4'b0010;
    cyc("R3", 0);
    clr();
    cyc("R8", 1);

    // R9 floor on thread 2 miss counter
    mode = 2; elig = 4'b0101;
    ms_dec = 4'b0100;
    repeat (5) cyc("R5", 0);
    ms_dec = 0; ms_inc = 4'b0001;
    cyc("R5", 0);
    clr();
    cyc("R9", 1);
    cyc("R9", 1);

    // R10 simultaneous inc/dec on thread 3 branch counter
    mode = 1; elig = 4'b1000;
    br_inc = 4'b1000;
    repeat (2) cyc("R4", 0);
    br_dec = 4'b1000;
    repeat (4) cyc("R10", 0);
    clr();
    elig = 4'b1100;
    br_inc = 4'b0100;
    repeat (2) cyc("R4", 0);
    clr();
    cyc("R10", 1);
    br_inc = 4'b0100;
    cyc("R10", 1);
    clr();
    cyc("R10", 1);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      mode = 2'($urandom_range(0, 3));
      elig = ($urandom_range(0, 9) == 0) ? '0 : NT'($urandom);
      ic_inc = NT'($urandom) & NT'($urandom);
      ic_dec = NT'($urandom) & NT'($urandom);
      br_inc = NT'($urandom) & NT'($urandom) & NT'($urandom);
      br_dec = NT'($urandom) & NT'($urandom);
      ms_inc = NT'($urandom) & NT'($urandom) & NT'($urandom);
      ms_dec = NT'($urandom) & NT'($urandom) & NT'($urandom);
      case (mode)
        2'd0: cyc("R3", 1);
        2'd1: cyc("R4", 1);
        2'd2: cyc("R5", 1);
        default: cyc("R6", 1);
      endcase
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule